// File: doc/BRIEF.md
# Multi-channel cell rate pacer

The pacer paces four cell-based PHY channels that share one transmit path. Each channel owns an 8-bit setting: a mode bit that picks internal pacing or external pacing, and a 7-bit reload value for a down-counting rate timer. All timers count the same reference enable, which is picked from four divider enables by a 2-bit select. A timer that reaches zero on an enabled cycle issues one tick and reloads, so a reload value N paces the channel at the reference rate divided by N+1. Each tick is one transmit opportunity: a cell-available poll when the controller is bus master, or one cell insertion when it is slave. In slave mode only channel 0 paces, using its own setting whatever the slave address is.

Each channel keeps a lag count of ticks that have no matching cell completion. When the lag climbs to seven the channel's underrun event is raised and stays raised until software clears it. Masked events are ORed into one interrupt line. Writing a channel's setting restarts its timer and forgets its lag.

Top module: `cell_pacer`

## Requirements
- R1: After reset every setting is zero, so every channel is in external mode; evt_o and irq_o are 0.
- R2: A channel whose mode bit (bit 7 of its setting) is 0 drives tick_o with its ext_req_i bit in the same cycle.
- R3: A channel whose mode bit is 1 ticks in a cycle only when the selected reference enable is high and its timer is zero. On that cycle the timer reloads from bits 6:0 of the setting; on other enabled cycles it counts down by one. The channel thus ticks once every reload+1 enabled cycles: 0x00 gives every enabled cycle and 0x7F gives one in 128.
- R4: ref_sel_i picks which bit of ref_en_i is the reference enable for all timers; the other enable bits have no effect.
- R5: While slave_i is 1, channels 1 to 3 give no ticks and channel 0 paces from its own setting.
- R6: The lag count of a channel goes up by one on a tick, goes down by one on a cell_done_i pulse, holds when both or neither occur, and stays between 0 and 7. evt_o for the channel is set at the edge where the lag count becomes or stays 7.
- R7: An event bit stays 1 until a cycle with its evt_clr_i bit at 1. Setting the event wins over clearing it in the same cycle.
- R8: irq_o is 1 exactly when some channel has its event bit and its evt_mask_i bit both at 1.
- R9: A write (wr_en_i, address wr_addr_i, data wr_data_i) stores the setting, loads the timer with wr_data_i[6:0], clears the lag count, and suppresses that channel's internal tick in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 4 | Divider enables, one per reference source |
| ref_sel_i | input | 2 | Index of the reference enable used by all timers |
| slave_i | input | 1 | 1 selects slave operation |
| wr_en_i | input | 1 | Setting write strobe |
| wr_addr_i | input | 2 | Channel written |
| wr_data_i | input | 8 | Bit 7 mode (1 internal), bits 6:0 reload value |
| ext_req_i | input | 4 | External pacing requests, one per channel |
| cell_done_i | input | 4 | Cell completion pulses, one per channel |
| evt_clr_i | input | 4 | Write-one-to-clear for the event bits |
| evt_mask_i | input | 4 | Interrupt enables for the event bits |
| tick_o | output | 4 | Transmit opportunity pulses, one per channel |
| evt_o | output | 4 | Sticky underrun events |
| irq_o | output | 1 | OR of the enabled events |

## Verification
The collisions of interest are a tick and a cell completion landing on the same channel in one cycle, which must leave the lag count unchanged, and an event clear arriving in the cycle the lag reaches or stays at seven, where the set must win. Both are provoked by random cell_done_i and evt_clr_i densities against fast reload values and a saturated lag, and are judged cycle by cycle against a bench model of the lag and event state through evt_o and irq_o.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
   localparam int CFG_W    = 8;
   localparam int MODE_BIT = CFG_W - 1;
   localparam int RLD_W    = CFG_W - 1;
   typedef enum logic {
      RATE_EXT = 1'b0,
      RATE_INT = 1'b1
   } rate_mode_e;
endpackage

// File: rtl/pacer_ref_sel.sv
module pacer_ref_sel #(
   parameter int NREF  = 4,
   parameter int SEL_W = 2
) (
   input  logic [NREF-1:0]  en_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             en_o
);
   generate
      if (NREF == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel_i;
         assign en_o = en_i[0];
      end else if ((1 << SEL_W) == NREF) begin : g_pow2
         assign en_o = en_i[sel_i];
      end else begin : g_guard
         always_comb begin
            en_o = 1'b0;
            for (int i = 0; i < NREF; i++)
               if (sel_i == SEL_W'(i)) en_o = en_i[i];
         end
      end
   endgenerate
endmodule

// File: rtl/pacer_rate_timer.sv
module pacer_rate_timer #(
   parameter int RLD_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [RLD_W-1:0] load_val_i,
   input  logic [RLD_W-1:0] reload_i,
   input  logic             int_mode_i,
   input  logic             ref_en_i,
   input  logic             ext_req_i,
   input  logic             gate_i,
   output logic             tick_o
);
   logic [RLD_W-1:0] cnt_q;
   logic             at_zero;
   logic             tick_int;

   assign at_zero  = (cnt_q == '0);
   assign tick_int = int_mode_i & ref_en_i & at_zero & ~load_i;
   assign tick_o   = gate_i & (int_mode_i ? tick_int : ext_req_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load_i)                  cnt_q <= load_val_i;
      else if (int_mode_i && ref_en_i)  cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
   end
endmodule

// File: rtl/pacer_lag_track.sv
module pacer_lag_track #(
   parameter int LAG_MAX = 7,
   localparam int LAG_W  = $clog2(LAG_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_lag_i,
   input  logic             up_i,
   input  logic             dn_i,
   input  logic             evt_clr_i,
   output logic [LAG_W-1:0] lag_o,
   output logic             evt_o
);
   logic [LAG_W-1:0] lag_d;
   logic             at_max;
   logic             at_min;

   assign at_max = (lag_o == LAG_W'(LAG_MAX));
   assign at_min = (lag_o == '0);

   always_comb begin
      lag_d = lag_o;
      if (clr_lag_i)                        lag_d = '0;
      else if (up_i && !dn_i && !at_max)    lag_d = lag_o + 1'b1;
      else if (dn_i && !up_i && !at_min)    lag_d = lag_o - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lag_o <= '0;
         evt_o <= 1'b0;
      end else begin
         lag_o <= lag_d;
         evt_o <= (evt_o & ~evt_clr_i) | (lag_d == LAG_W'(LAG_MAX));
      end
   end
endmodule

// File: rtl/cell_pacer.sv
module cell_pacer #(
   parameter int NCH     = 4,
   parameter int NREF    = 4,
   parameter int LAG_MAX = 7,
   localparam int CFG_W  = pacer_pkg::CFG_W,
   localparam int RLD_W  = pacer_pkg::RLD_W,
   localparam int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int SEL_W  = (NREF > 1) ? $clog2(NREF) : 1,
   localparam int LAG_W  = $clog2(LAG_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREF-1:0]   ref_en_i,
   input  logic [SEL_W-1:0]  ref_sel_i,
   input  logic              slave_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CFG_W-1:0]  wr_data_i,
   input  logic [NCH-1:0]    ext_req_i,
   input  logic [NCH-1:0]    cell_done_i,
   input  logic [NCH-1:0]    evt_clr_i,
   input  logic [NCH-1:0]    evt_mask_i,
   output logic [NCH-1:0]    tick_o,
   output logic [NCH-1:0]    evt_o,
   output logic              irq_o
);
   import pacer_pkg::*;

   generate
      if (NCH < 1)         begin : g_bad_nch  $error("NCH must be at least 1"); end
      if (NREF < 1)        begin : g_bad_nref $error("NREF must be at least 1"); end
      if (LAG_MAX < 1)     begin : g_bad_lag  $error("LAG_MAX must be at least 1"); end
   endgenerate

   logic                           ref_en;
   logic [NCH-1:0][CFG_W-1:0]      cfg_q;
   logic [NCH-1:0]                 int_mode;
   logic [NCH-1:0]                 wr_hit;
   logic [NCH-1:0][LAG_W-1:0]      lag_q;

   pacer_ref_sel #(.NREF(NREF), .SEL_W(SEL_W)) u_ref (
      .en_i  (ref_en_i),
      .sel_i (ref_sel_i),
      .en_o  (ref_en)
   );

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         logic gate;
         assign wr_hit[k]   = wr_en_i && (wr_addr_i == ADDR_W'(k));
         assign int_mode[k] = (rate_mode_e'(cfg_q[k][MODE_BIT]) == RATE_INT);

         if (k == 0) begin : g_master_ch
            assign gate = 1'b1;
         end else begin : g_other_ch
            assign gate = ~slave_i;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cfg_q[k] <= '0;
            else if (wr_hit[k])  cfg_q[k] <= wr_data_i;
         end

         pacer_rate_timer #(.RLD_W(RLD_W)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (wr_hit[k]),
            .load_val_i (wr_data_i[RLD_W-1:0]),
            .reload_i   (cfg_q[k][RLD_W-1:0]),
            .int_mode_i (int_mode[k]),
            .ref_en_i   (ref_en),
            .ext_req_i  (ext_req_i[k]),
            .gate_i     (gate),
            .tick_o     (tick_o[k])
         );

         pacer_lag_track #(.LAG_MAX(LAG_MAX)) u_lag (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_lag_i (wr_hit[k]),
            .up_i      (tick_o[k]),
            .dn_i      (cell_done_i[k]),
            .evt_clr_i (evt_clr_i[k]),
            .lag_o     (lag_q[k]),
            .evt_o     (evt_o[k])
         );
      end
   endgenerate

   assign irq_o = |(evt_o & evt_mask_i);
endmodule

// File: rtl/cell_pacer_chk.sv
module cell_pacer_chk #(
   parameter int NCH     = 4,
   parameter int NREF    = 4,
   parameter int LAG_MAX = 7,
   localparam int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int SEL_W  = (NREF > 1) ? $clog2(NREF) : 1,
   localparam int LAG_W  = $clog2(LAG_MAX + 1)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NREF-1:0]           ref_en_i,
   input logic [SEL_W-1:0]          ref_sel_i,
   input logic                      slave_i,
   input logic                      wr_en_i,
   input logic [ADDR_W-1:0]         wr_addr_i,
   input logic [NCH-1:0]            evt_clr_i,
   input logic [NCH-1:0]            evt_mask_i,
   input logic [NCH-1:0]            int_mode,
   input logic [NCH-1:0][LAG_W-1:0] lag_q,
   input logic [NCH-1:0]            tick_o,
   input logic [NCH-1:0]            evt_o,
   input logic                      irq_o
);
   generate
      if (NCH > 1) begin : g_slave
         a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            slave_i |-> (tick_o[NCH-1:1] == '0));
      end
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         a_r3_tick_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
            (int_mode[k] && tick_o[k]) |-> ref_en_i[ref_sel_i]);
         a_r6_full_lag_flags: assert property (@(posedge clk) disable iff (!rst_n)
            (lag_q[k] == LAG_W'(LAG_MAX)) |-> evt_o[k]);
         a_r9_write_clears_lag: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == ADDR_W'(k)) |=> (lag_q[k] == '0));
         a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_o[k] && !evt_clr_i[k]) |=> evt_o[k]);
      end
   endgenerate

   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_mask_i == '0) |-> !irq_o);
endmodule

bind cell_pacer cell_pacer_chk #(.NCH(NCH), .NREF(NREF), .LAG_MAX(LAG_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_en_i   (ref_en_i),
   .ref_sel_i  (ref_sel_i),
   .slave_i    (slave_i),
   .wr_en_i    (wr_en_i),
   .wr_addr_i  (wr_addr_i),
   .evt_clr_i  (evt_clr_i),
   .evt_mask_i (evt_mask_i),
   .int_mode   (int_mode),
   .lag_q      (lag_q),
   .tick_o     (tick_o),
   .evt_o      (evt_o),
   .irq_o      (irq_o)
);

// File: tb/sim_cell_pacer.sv
`timescale 1ns/1ps
module sim_cell_pacer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ref_en_i = '0;
   logic [1:0] ref_sel_i = '0;
   logic       slave_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [3:0] ext_req_i = '0;
   logic [3:0] cell_done_i = '0;
   logic [3:0] evt_clr_i = '0;
   logic [3:0] evt_mask_i = '0;
   logic [3:0] tick_o;
   logic [3:0] evt_o;
   logic       irq_o;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] m_reg [4];
   logic [6:0] m_cnt [4];
   int         m_lag [4];
   logic [3:0] m_evt;

   always #2.5 clk = ~clk;

   cell_pacer u0 (.*);

   function automatic logic [3:0] exp_tick();
      logic [3:0] t;
      logic refon;
      refon = ref_en_i[ref_sel_i];
      for (int k = 0; k < 4; k++) begin
         logic hit;
         hit = wr_en_i && (wr_addr_i == 2'(k));
         if (m_reg[k][7]) t[k] = refon && (m_cnt[k] == 7'd0) && !hit;
         else             t[k] = ext_req_i[k];
         if (slave_i && k != 0) t[k] = 1'b0;
      end
      return t;
   endfunction

   function automatic logic exp_irq();
      return |(m_evt & evt_mask_i);
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 4; k++) begin
         m_reg[k] = '0; m_cnt[k] = '0; m_lag[k] = 0;
      end
      m_evt = '0;
   endtask

   task automatic model_advance(input logic [3:0] t);
      logic refon;
      refon = ref_en_i[ref_sel_i];
      for (int k = 0; k < 4; k++) begin
         logic hit;
         int nl;
         hit = wr_en_i && (wr_addr_i == 2'(k));
         nl = m_lag[k];
         if (hit) nl = 0;
         else if (t[k] && !cell_done_i[k] && nl < 7) nl++;
         else if (cell_done_i[k] && !t[k] && nl > 0) nl--;
         if (hit) m_cnt[k] = wr_data_i[6:0];
         else if (m_reg[k][7] && refon)
            m_cnt[k] = (m_cnt[k] == 7'd0) ? m_reg[k][6:0] : m_cnt[k] - 7'd1;
         if (hit) m_reg[k] = wr_data_i;
         m_lag[k] = nl;
         m_evt[k] = (m_evt[k] & ~evt_clr_i[k]) | (nl == 7);
      end
   endtask

   task automatic cmp(input string tag, input string what, input logic [3:0] got, input logic [3:0] exp);
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
      end
   endtask

   // caller sets inputs just after a falling edge
   task automatic step(input string tag);
      logic [3:0] t;
      #1;
      t = exp_tick();
      vectors++;
      cmp(tag, "tick_o", tick_o, t);
      cmp(tag, "evt_o", evt_o, m_evt);
      cmp(tag, "irq_o", {3'b0, irq_o}, {3'b0, exp_irq()});
      @(posedge clk);
      model_advance(t);
      @(negedge clk);
   endtask

   task automatic quiet();
      wr_en_i = 0; cell_done_i = '0; evt_clr_i = '0; ext_req_i = '0; ref_en_i = '0;
   endtask

   task automatic write(input string tag, input int a, input logic [7:0] d);
      quiet();
      wr_en_i = 1; wr_addr_i = 2'(a); wr_data_i = d;
      step(tag);
      wr_en_i = 0;
   endtask

   task automatic rnd(input int p_wr, input int p_done, input int p_clr, input bit force_int);
      ref_en_i    = 4'($urandom);
      ext_req_i   = 4'($urandom);
      wr_en_i     = ($urandom % 100) < p_wr;
      wr_addr_i   = 2'($urandom);
      wr_data_i   = 8'($urandom);
      if (force_int) wr_data_i[7] = 1'b1;
      if (($urandom % 4) == 0) wr_data_i[6:0] = 7'($urandom % 3);
      for (int k = 0; k < 4; k++) begin
         cell_done_i[k] = ($urandom % 100) < p_done;
         evt_clr_i[k]   = ($urandom % 100) < p_clr;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, all channels external
      ext_req_i = 4'b1010; step("R1");
      ext_req_i = 4'b0101; evt_mask_i = 4'hF; step("R1");

      // R2: external mode follows requests
      for (int i = 0; i < 200; i++) begin rnd(0, 30, 5, 0); step("R2"); end

      // R3: internal pacing, fastest and slowest reload
      write("R3", 0, 8'h80);
      write("R3", 1, 8'hFF);
      write("R3", 2, 8'h83);
      write("R3", 3, 8'h00);
      for (int i = 0; i < 300; i++) begin
         quiet(); ref_en_i = 4'hF; cell_done_i = 4'hF; step("R3");
      end
      for (int i = 0; i < 2500; i++) begin rnd(2, 40, 5, 1); step("R3"); end

      // R4: only the selected enable counts
      write("R4", 0, 8'h80);
      for (int s = 0; s < 4; s++) begin
         ref_sel_i = 2'(s);
         quiet(); ref_en_i = ~(4'b1 << s); step("R4");
         quiet(); ref_en_i = 4'b1 << s;    step("R4");
      end
      for (int i = 0; i < 400; i++) begin ref_sel_i = 2'($urandom); rnd(2, 40, 5, 1); step("R4"); end
      ref_sel_i = 2'd0;

      // R5: slave mode uses channel 0 only
      slave_i = 1;
      for (int i = 0; i < 1500; i++) begin rnd(3, 30, 5, ($urandom % 2) == 1); step("R5"); end
      slave_i = 0;

      // R6: lag saturation and event raise, then drain
      for (int k = 0; k < 4; k++) write("R6", k, 8'h80);
      for (int i = 0; i < 12; i++) begin quiet(); ref_en_i = 4'hF; step("R6"); end
      for (int i = 0; i < 12; i++) begin quiet(); cell_done_i = 4'hF; step("R6"); end
      for (int i = 0; i < 8; i++) begin quiet(); ref_en_i = 4'hF; cell_done_i = 4'b0101; step("R6"); end

      // R7: clear against a saturated lag and after draining
      for (int i = 0; i < 10; i++) begin quiet(); ref_en_i = 4'hF; evt_clr_i = 4'b0011; step("R7"); end
      for (int i = 0; i < 3; i++) begin quiet(); cell_done_i = 4'hF; step("R7"); end
      quiet(); evt_clr_i = 4'hF; step("R7");
      quiet(); step("R7");
      for (int i = 0; i < 800; i++) begin rnd(1, 35, 30, 1); step("R7"); end

      // R8: interrupt masking
      for (int i = 0; i < 500; i++) begin
         rnd(2, 30, 8, 1);
         evt_mask_i = 4'($urandom);
         step("R8");
      end
      evt_mask_i = '0;
      for (int i = 0; i < 50; i++) begin rnd(0, 10, 0, 1); step("R8"); end

      // R9: writes restart timers and clear lag
      for (int k = 0; k < 4; k++) write("R9", k, 8'h80);
      for (int i = 0; i < 10; i++) begin quiet(); ref_en_i = 4'hF; step("R9"); end
      for (int k = 0; k < 4; k++) begin quiet(); ref_en_i = 4'hF; wr_en_i = 1; wr_addr_i = 2'(k); wr_data_i = 8'h80; step("R9"); end
      evt_mask_i = 4'hF;
      for (int i = 0; i < 1000; i++) begin rnd(20, 40, 10, 0); step("R9"); end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule